// File: doc/BRIEF.md
# DMA Channel Run and Error Control

This block holds the control and status logic of a group of DMA channels. Each channel drives a request interface toward a memory port and counts the requests it has outstanding. It takes back read responses and write acknowledges. A fixed-length work unit stands in for descriptor handling, and the channel signals the end of each unit with an interrupt. Software sets and clears an enable bit for each channel. Clearing it stops new issue but lets requests already in flight finish. Setting it again wipes the channel's internal state.

Error detection stops a channel at once. The channel then drops read data that arrives late and drains its outstanding requests. It latches the cause of the first error only, raises an error interrupt, and leaves its counters as they were at the moment of failure so software can inspect them. A channel never restarts by itself. Software clears the error status, then turns the enable off and on again. The error interrupts of all channels are combined into one shared line, and software polls each channel's status to find the source.

Top module: `dmx_chan_group`

## Requirements
- R1: After reset every channel reports run state 00 (idle) and error cause 0, and it drives no request and no interrupt.
- R2: A channel in run state 01 (running) offers a request whenever it is enabled and fewer than 15 requests are outstanding, counting at most 15. The request direction follows the channel's direction bit.
- R3: The run state reads 10 (draining) while any request is still outstanding after a stop, and it reads 00 only once every request has been answered by a read response or a write acknowledge.
- R4: From the cycle in which the enable bit is low, no new request is offered. Requests already issued still complete and are answered normally.
- R5: The work-unit interrupt is a one-cycle pulse in the cycle after the return that completes each run of 6 returns. No pulse is raised while the enable bit is low, and none is raised after an error.
- R6: An error input with a nonzero 3-bit code on an active channel blocks issue in that same cycle. Read responses in that cycle and later are not forwarded, and the channel drains to idle.
- R7: The cycle after an error, the per-channel error interrupt rises. It holds until a status-clear write.
- R8: The 3-bit error cause holds the code of the first error only. Later errors leave it unchanged until a status-clear write sets it to 0.
- R9: The issued-beat counter of the current work unit keeps the value it had when the error struck.
- R10: A stopped channel stays idle until the enable bit goes from 0 to 1. That rising edge zeroes the counters and outstanding count. The channel enters running only if the error cause is 0 and otherwise stays idle.
- R11: The shared error interrupt is high whenever any channel's error interrupt is high.
- R12: When an error and a disable arrive in the same cycle, the error cause is latched and the error interrupt raised.
- R13: An error input on an idle channel is ignored: no cause is latched and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en | input | NUM_CH | Enable bit per channel |
| cfg_wr | input | NUM_CH | Direction per channel, 1 = write |
| req_valid | output | NUM_CH | Request offered to the memory port |
| req_ready | input | NUM_CH | Memory port accepts the request |
| req_wr | output | NUM_CH | Direction of the offered request |
| rsp_valid | input | NUM_CH | Read response returns |
| rsp_data | input | NUM_CH*DATA_W | Read response data |
| wack_valid | input | NUM_CH | Write acknowledge returns |
| out_valid | output | NUM_CH | Read data forwarded to the channel's consumer |
| out_data | output | NUM_CH*DATA_W | Forwarded read data |
| err_det | input | NUM_CH | Error detected |
| err_code | input | NUM_CH*3 | Cause of the detected error, nonzero |
| stat_clr | input | NUM_CH | Status-clear write: cause and error flag |
| stat_run | output | NUM_CH*2 | Run state: 00 idle, 01 running, 10 draining |
| stat_errc | output | NUM_CH*3 | Latched first error cause |
| stat_issued | output | NUM_CH*CNT_W | Beats issued in the current work unit |
| err_irq | output | NUM_CH | Per-channel error interrupt and status flag |
| done_irq | output | NUM_CH | Work-unit completion pulse |
| err_irq_shared | output | 1 | OR of all channel error interrupts |

## Verification
The assertions assume that the memory side never returns more responses and acknowledges than there are requests outstanding. They also assume that software re-enables a channel only after it has reached idle. The stimulus keeps to both rules. It raises a return only when the bench's own model counts at least one request in flight, and it waits for the model's idle state before driving a rising enable. Error codes are always driven nonzero except where a zero-code case is meant. Status clears are never driven in the same cycle as a re-enable.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int ERRC_W = 3;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'b00,
    RS_RUN   = 2'b01,
    RS_DRAIN = 2'b10
  } run_st_t;

  // advance a modulo counter by add, wrapping at lim
  function automatic int unsigned wrap_add(int unsigned cur, int unsigned add, int unsigned lim);
    int unsigned s;
    s = cur + add;
    return (s >= lim) ? s - lim : s;
  endfunction

  // does adding add to cur reach or pass lim
  function automatic logic reaches(int unsigned cur, int unsigned add, int unsigned lim);
    return (cur + add) >= lim;
  endfunction
endpackage

// File: rtl/dmx_ost_tracker.sv
module dmx_ost_tracker #(
  parameter int OST_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_clr,
  input  logic             inc,
  input  logic [1:0]       dec,
  output logic [OST_W-1:0] cnt,
  output logic             full,
  output logic             zero_nxt
);
  localparam logic [OST_W-1:0] MAXV = {OST_W{1'b1}};

  logic [OST_W-1:0] nxt;

  assign nxt      = cnt + OST_W'(inc) - OST_W'(dec);
  assign full     = (cnt == MAXV);
  assign zero_nxt = (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (hard_clr) cnt <= '0;
    else               cnt <= nxt;
  end

  // R2: a saturated count must never see another issue
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !inc);
  // R3: returns never exceed what is in flight
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hard_clr |-> ({2'b00, cnt} + {{OST_W+1{1'b0}}, inc}) >= {{OST_W{1'b0}}, dec});
endmodule

// File: rtl/dmx_err_capture.sv
module dmx_err_capture
  import dmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_now,
  input  logic [ERRC_W-1:0] code,
  input  logic              clr,
  output logic [ERRC_W-1:0] errc,
  output logic              irq_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errc     <= '0;
      irq_flag <= 1'b0;
    end else if (err_now) begin
      if (errc == '0) errc <= code;
      irq_flag <= 1'b1;
    end else if (clr) begin
      errc     <= '0;
      irq_flag <= 1'b0;
    end
  end

  // R8: a held cause stays put until cleared
  assert_errc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (errc != '0 && !clr) |=> $stable(errc));
  // R7: an error always raises the flag next cycle
  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |=> irq_flag);
endmodule

// File: rtl/dmx_chan_ctl.sv
module dmx_chan_ctl
  import dmx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OST_W      = 4,
  parameter int UNIT_BEATS = 6,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_wr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_wr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              wack_valid,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              err_det,
  input  logic [ERRC_W-1:0] err_code,
  input  logic              stat_clr,
  output logic [1:0]        stat_run,
  output logic [ERRC_W-1:0] stat_errc,
  output logic [CNT_W-1:0]  stat_issued,
  output logic              err_irq,
  output logic              done_irq
);
  run_st_t          st;
  logic             en_q;
  logic             halted;
  logic [CNT_W-1:0] issued;
  logic [CNT_W-1:0] acked;
  logic             done_q;

  // named internal events
  logic             en_rise;
  logic             err_now;
  logic             issue_fire;
  logic             count_ok;
  logic             unit_hit;
  logic [1:0]       ret_cnt;
  logic [1:0]       ret_eff;
  logic [OST_W-1:0] ost;
  logic             ost_full;
  logic             ost_zero_nxt;
  logic [ERRC_W-1:0] errc;
  logic             irq_flag;

  assign en_rise    = cfg_en & ~en_q;
  assign err_now    = err_det & (err_code != '0) & (st != RS_IDLE) & ~en_rise;
  assign req_valid  = (st == RS_RUN) & cfg_en & ~halted & ~err_now & ~ost_full & ~en_rise;
  assign req_wr     = cfg_wr;
  assign issue_fire = req_valid & req_ready;
  assign ret_cnt    = {1'b0, rsp_valid} + {1'b0, wack_valid};
  assign count_ok   = ~halted & ~err_now & ~en_rise & (st != RS_IDLE);
  assign ret_eff    = count_ok ? ret_cnt : 2'd0;
  assign unit_hit   = reaches(32'(acked), 32'(ret_eff), UNIT_BEATS);
  assign out_valid  = rsp_valid & count_ok;
  assign out_data   = rsp_data;

  dmx_ost_tracker #(.OST_W(OST_W)) u_ost (
    .clk      (clk),
    .rst_n    (rst_n),
    .hard_clr (en_rise),
    .inc      (issue_fire),
    .dec      (ret_cnt),
    .cnt      (ost),
    .full     (ost_full),
    .zero_nxt (ost_zero_nxt)
  );

  dmx_err_capture u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_now  (err_now),
    .code     (err_code),
    .clr      (stat_clr),
    .errc     (errc),
    .irq_flag (irq_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      st     <= RS_IDLE;
      halted <= 1'b0;
      issued <= '0;
      acked  <= '0;
      done_q <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (en_rise) begin
        st     <= (errc == '0) ? RS_RUN : RS_IDLE;
        halted <= 1'b0;
        issued <= '0;
        acked  <= '0;
        done_q <= 1'b0;
      end else begin
        done_q <= count_ok & cfg_en & unit_hit;
        if (issue_fire) issued <= CNT_W'(wrap_add(32'(issued), 32'd1, UNIT_BEATS));
        if (count_ok)   acked  <= CNT_W'(wrap_add(32'(acked), 32'(ret_eff), UNIT_BEATS));
        if (err_now)    halted <= 1'b1;
        case (st)
          RS_RUN:   if (err_now || !cfg_en) st <= ost_zero_nxt ? RS_IDLE : RS_DRAIN;
          RS_DRAIN: if (ost_zero_nxt) st <= RS_IDLE;
          default:  st <= RS_IDLE;
        endcase
      end
    end
  end

  assign stat_run    = st;
  assign stat_errc   = errc;
  assign stat_issued = issued;
  assign err_irq     = irq_flag;
  assign done_irq    = done_q;

  // R3: idle is only reported with nothing in flight
  assert_idle_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_IDLE) |-> (ost == '0));
  // R4: a disabled channel offers nothing
  assert_no_issue_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !req_valid);
  // R6: an error-stopped channel never sits in running
  assert_halt_not_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (st != RS_RUN));
  // R5: a unit pulse follows an enabled cycle
  assert_done_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(cfg_en));
endmodule

// File: rtl/dmx_chan_group.sv
module dmx_chan_group
  import dmx_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int DATA_W     = 8,
  parameter int OST_W      = 4,
  parameter int UNIT_BEATS = 6,
  parameter int CNT_W      = (UNIT_BEATS > 2) ? $clog2(UNIT_BEATS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          cfg_en,
  input  logic [NUM_CH-1:0]          cfg_wr,
  output logic [NUM_CH-1:0]          req_valid,
  input  logic [NUM_CH-1:0]          req_ready,
  output logic [NUM_CH-1:0]          req_wr,
  input  logic [NUM_CH-1:0]          rsp_valid,
  input  logic [NUM_CH*DATA_W-1:0]   rsp_data,
  input  logic [NUM_CH-1:0]          wack_valid,
  output logic [NUM_CH-1:0]          out_valid,
  output logic [NUM_CH*DATA_W-1:0]   out_data,
  input  logic [NUM_CH-1:0]          err_det,
  input  logic [NUM_CH*ERRC_W-1:0]   err_code,
  input  logic [NUM_CH-1:0]          stat_clr,
  output logic [NUM_CH*2-1:0]        stat_run,
  output logic [NUM_CH*ERRC_W-1:0]   stat_errc,
  output logic [NUM_CH*CNT_W-1:0]    stat_issued,
  output logic [NUM_CH-1:0]          err_irq,
  output logic [NUM_CH-1:0]          done_irq,
  output logic                       err_irq_shared
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmx_chan_ctl #(
      .DATA_W(DATA_W), .OST_W(OST_W), .UNIT_BEATS(UNIT_BEATS), .CNT_W(CNT_W)
    ) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_en      (cfg_en[c]),
      .cfg_wr      (cfg_wr[c]),
      .req_valid   (req_valid[c]),
      .req_ready   (req_ready[c]),
      .req_wr      (req_wr[c]),
      .rsp_valid   (rsp_valid[c]),
      .rsp_data    (rsp_data[c*DATA_W +: DATA_W]),
      .wack_valid  (wack_valid[c]),
      .out_valid   (out_valid[c]),
      .out_data    (out_data[c*DATA_W +: DATA_W]),
      .err_det     (err_det[c]),
      .err_code    (err_code[c*ERRC_W +: ERRC_W]),
      .stat_clr    (stat_clr[c]),
      .stat_run    (stat_run[c*2 +: 2]),
      .stat_errc   (stat_errc[c*ERRC_W +: ERRC_W]),
      .stat_issued (stat_issued[c*CNT_W +: CNT_W]),
      .err_irq     (err_irq[c]),
      .done_irq    (done_irq[c])
    );
  end

  // R11: one shared line for all channel errors
  assign err_irq_shared = |err_irq;
endmodule

// File: tb/sim_dmx_chan_group.sv
module sim_dmx_chan_group;
  localparam int NCH = 2;
  localparam int DW  = 8;
  localparam int U   = 6;
  localparam int CW  = 3;
  localparam int OSTMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NCH-1:0] en, wr, rdy, rsp, wack, edet, clr;
  logic [NCH*DW-1:0] rdat;
  logic [NCH*3-1:0] ecode;
  logic [NCH-1:0] req_valid, req_wr, out_valid, err_irq, done_irq;
  logic [NCH*DW-1:0] out_data;
  logic [NCH*2-1:0] stat_run;
  logic [NCH*3-1:0] stat_errc;
  logic [NCH*CW-1:0] stat_issued;
  logic shared;

  dmx_chan_group #(.NUM_CH(NCH), .DATA_W(DW), .OST_W(4), .UNIT_BEATS(U)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(en), .cfg_wr(wr),
    .req_valid(req_valid), .req_ready(rdy), .req_wr(req_wr),
    .rsp_valid(rsp), .rsp_data(rdat), .wack_valid(wack),
    .out_valid(out_valid), .out_data(out_data),
    .err_det(edet), .err_code(ecode), .stat_clr(clr),
    .stat_run(stat_run), .stat_errc(stat_errc), .stat_issued(stat_issued),
    .err_irq(err_irq), .done_irq(done_irq), .err_irq_shared(shared)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ret_on [NCH];
  int rdy_all = 0;

  // reference model state
  int m_enq [NCH], m_st [NCH], m_ost [NCH], m_iss [NCH], m_ack [NCH];
  int m_halt [NCH], m_errc [NCH], m_irq [NCH], m_done [NCH];

  function automatic int rise_of(int c);
    return (en[c] && m_enq[c] == 0) ? 1 : 0;
  endfunction
  function automatic int errn_of(int c);
    return (edet[c] && ecode[c*3 +: 3] != 0 && m_st[c] != 0 && !rise_of(c)) ? 1 : 0;
  endfunction
  function automatic int mreq(int c);
    return (m_st[c] == 1 && en[c] && !m_halt[c] && !errn_of(c) && m_ost[c] < OSTMAX && !rise_of(c)) ? 1 : 0;
  endfunction
  function automatic int mok(int c);
    return (!m_halt[c] && !errn_of(c) && !rise_of(c) && m_st[c] != 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      int rise, errn, fire, ret, ok, nost, olde;
      rise = rise_of(c); errn = errn_of(c); ok = mok(c);
      fire = mreq(c) && rdy[c];
      ret = int'(rsp[c]) + int'(wack[c]);
      olde = m_errc[c];
      if (!rst_n) begin
        m_enq[c] = 0; m_st[c] = 0; m_ost[c] = 0; m_iss[c] = 0; m_ack[c] = 0;
        m_halt[c] = 0; m_errc[c] = 0; m_irq[c] = 0; m_done[c] = 0;
      end else begin
        if (errn) begin
          if (m_errc[c] == 0) m_errc[c] = int'(ecode[c*3 +: 3]);
          m_irq[c] = 1;
        end else if (clr[c]) begin
          m_errc[c] = 0; m_irq[c] = 0;
        end
        if (rise) begin
          m_st[c] = (olde == 0) ? 1 : 0;
          m_ost[c] = 0; m_iss[c] = 0; m_ack[c] = 0; m_halt[c] = 0; m_done[c] = 0;
        end else begin
          nost = m_ost[c] + fire - ret;
          m_done[c] = (ok && en[c] && (m_ack[c] + ret >= U)) ? 1 : 0;
          if (fire) m_iss[c] = (m_iss[c] + 1) % U;
          if (ok) m_ack[c] = (m_ack[c] + ret) % U;
          if (errn) m_halt[c] = 1;
          if (m_st[c] == 1 && (errn || !en[c])) m_st[c] = (nost == 0) ? 0 : 2;
          else if (m_st[c] == 2 && nost == 0) m_st[c] = 0;
          m_ost[c] = nost;
        end
        m_enq[c] = int'(en[c]);
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic compare_all();
    int anyirq;
    anyirq = 0;
    for (int c = 0; c < NCH; c++) begin
      chk($sformatf("R2 req_valid ch%0d", c), int'(req_valid[c]), mreq(c));
      if (req_valid[c]) chk($sformatf("R2 req_wr ch%0d", c), int'(req_wr[c]), int'(wr[c]));
      chk($sformatf("R6 out_valid ch%0d", c), int'(out_valid[c]), (rsp[c] && mok(c)) ? 1 : 0);
      if (out_valid[c]) chk($sformatf("R6 out_data ch%0d", c), int'(out_data[c*DW +: DW]), int'(rdat[c*DW +: DW]));
      chk($sformatf("R3 stat_run ch%0d", c), int'(stat_run[c*2 +: 2]), m_st[c]);
      chk($sformatf("R8 stat_errc ch%0d", c), int'(stat_errc[c*3 +: 3]), m_errc[c]);
      chk($sformatf("R7 err_irq ch%0d", c), int'(err_irq[c]), m_irq[c]);
      chk($sformatf("R9 stat_issued ch%0d", c), int'(stat_issued[c*CW +: CW]), m_iss[c]);
      chk($sformatf("R5 done_irq ch%0d", c), int'(done_irq[c]), m_done[c]);
      if (m_irq[c] != 0) anyirq = 1;
    end
    chk("R11 err_irq_shared", int'(shared), anyirq);
  endtask

  // one cycle: inputs set by the caller at a negedge, random returns added here
  task automatic step();
    for (int c = 0; c < NCH; c++) begin
      rdy[c] = rdy_all ? 1'b1 : 1'($urandom % 2);
      rsp[c] = 1'b0; wack[c] = 1'b0;
      if (ret_on[c] != 0 && m_ost[c] > 0 && ($urandom % 2) == 1) begin
        if (wr[c]) wack[c] = 1'b1; else rsp[c] = 1'b1;
      end
      rdat[c*DW +: DW] = DW'($urandom);
    end
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic drain(int c);
    for (int i = 0; i < 300 && m_st[c] != 0; i++) step();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int snap;
    en = '0; wr = 2'b10; rdy = '0; rsp = '0; wack = '0; edet = '0; clr = '0;
    rdat = '0; ecode = '0;
    for (int c = 0; c < NCH; c++) ret_on[c] = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stat_run", int'(stat_run), 0);
    chk("R1 stat_errc", int'(stat_errc), 0);
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 irqs", int'({err_irq, done_irq, shared}), 0);
    rst_n = 1'b1;
    step();

    // running traffic on both channels
    en = 2'b11;
    repeat (80) step();

    // R2: fill channel 0 to the outstanding limit
    ret_on[0] = 0; rdy_all = 1;
    repeat (25) step();
    chk("R2 saturated no request", int'(req_valid[0]), 0);
    rdy_all = 0; ret_on[0] = 1;
    repeat (10) step();

    // R4: disable with requests in flight
    ret_on[0] = 0;
    repeat (4) step();
    en[0] = 1'b0;
    step();
    chk("R4 no request after disable", int'(req_valid[0]), 0);
    chk("R3 draining with requests in flight", int'(stat_run[1:0]), 2);
    ret_on[0] = 1;
    drain(0);
    chk("R3 idle after drain", int'(stat_run[1:0]), 0);
    repeat (3) step();
    chk("R10 stays idle without re-enable", int'(stat_run[1:0]), 0);

    // R10: re-enable resets counters and runs
    en[0] = 1'b1;
    step();
    chk("R10 running after re-enable", int'(stat_run[1:0]), 1);
    chk("R10 issued zeroed", int'(stat_issued[CW-1:0]), 0);
    repeat (30) step();

    // R6 R8 R9: error with requests outstanding
    ret_on[0] = 0; rdy_all = 1;
    repeat (3) step();
    rdy_all = 0;
    snap = int'(stat_issued[CW-1:0]);
    edet[0] = 1'b1; ecode[2:0] = 3'd5;
    step();
    ret_on[0] = 1;
    ecode[2:0] = 3'd3;
    step();
    edet[0] = 1'b0; ecode[2:0] = 3'd0;
    chk("R7 err_irq raised", int'(err_irq[0]), 1);
    chk("R11 shared raised", int'(shared), 1);
    drain(0);
    chk("R8 first cause kept", int'(stat_errc[2:0]), 5);
    chk("R9 issued frozen", int'(stat_issued[CW-1:0]), snap);
    chk("R6 idle after error drain", int'(stat_run[1:0]), 0);

    // R10: re-enable without clearing stays idle
    en[0] = 1'b0; step();
    en[0] = 1'b1; step();
    step();
    chk("R10 idle while cause held", int'(stat_run[1:0]), 0);
    chk("R10 no request while cause held", int'(req_valid[0]), 0);

    // recovery: clear, disable, enable
    clr[0] = 1'b1; step(); clr[0] = 1'b0;
    chk("R7 flag cleared", int'(err_irq[0]), 0);
    en[0] = 1'b0; step();
    en[0] = 1'b1; step();
    chk("R10 running after recovery", int'(stat_run[1:0]), 1);
    repeat (20) step();

    // R12: error and disable on channel 1 in one cycle
    for (int i = 0; i < 50 && m_st[1] != 1; i++) step();
    en[1] = 1'b0; edet[1] = 1'b1; ecode[5:3] = 3'd2;
    step();
    edet[1] = 1'b0; ecode[5:3] = 3'd0;
    chk("R12 cause latched with disable", int'(stat_errc[5:3]), 2);
    chk("R12 irq raised with disable", int'(err_irq[1]), 1);
    drain(1);

    // R13: error on idle channel ignored
    clr[1] = 1'b1; step(); clr[1] = 1'b0;
    edet[1] = 1'b1; ecode[5:3] = 3'd6;
    step();
    edet[1] = 1'b0; ecode[5:3] = 3'd0;
    step();
    chk("R13 idle error no cause", int'(stat_errc[5:3]), 0);
    chk("R13 idle error no irq", int'(err_irq[1]), 0);

    // R5: steady traffic with channel 0 enabled for unit pulses
    repeat (60) step();
    en[0] = 1'b0;
    drain(0);
    repeat (5) step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule